// File: doc/BRIEF.md
# Framed serial I/Q input deserializer

This block takes baseband I/Q samples that arrive over a small group of serial data pins and turns them into parallel I and Q words for an upconverter datapath. A programmable divider makes a bit clock from the input clock, and each bit time is one sampling opportunity. A frame sequencer counts bit times so that a word starts at a fixed position in every frame. It also drives a frame strobe output, which tells the sender when the next word's most significant bit is due.

A sync input restarts the divider and the frame sequencer. The first word's MSB is therefore tied to the sync and not to the strobe, and a sender may ignore the strobe. There are two pin modes. In two-pin mode one pin carries the I word and another carries the Q word. In four-pin mode each component uses two pins and two bits arrive per bit time, which halves the bit times needed per word. If the frame interval is too short for the selected word length and mode, the block raises an error flag and produces no words, rather than cutting words short.

Top module: `ser_iq_deser`

## Requirements
- R1: A bit time occurs once every `cfg_clkdiv`+1 input clocks. When `sync_in` is seen, the divider restarts its count and no sample is taken in the restart cycle.
- R2: If `sync_in` is high at input-clock edge E0, the first MSB is sampled at edge E0+3+`cfg_clkdiv`. That is the 3rd edge at full rate and the 4th edge at half rate. Later samples follow every `cfg_clkdiv`+1 edges.
- R3: Two-pin mode (`cfg_four_pin`=0). At each sampled bit time, `ser_pins[0]` supplies the next I bit and `ser_pins[1]` supplies the next Q bit, MSB first.
- R4: Four-pin mode (`cfg_four_pin`=1). At each sampled bit time, the next two I bits (higher first) come on `ser_pins[0]` and `ser_pins[1]`, and the next two Q bits come on `ser_pins[2]` and `ser_pins[3]`. A word of length L therefore takes ceil(L/2) bit times. When L is odd, the final bit time takes only `ser_pins[0]` and `ser_pins[2]`.
- R5: The word length is `cfg_bits`+1. `out_i` and `out_q` hold the word right-aligned, and every bit above the word length reads 0.
- R6: A frame lasts `cfg_interval` bit times. A word occupies the first bit times of each frame, and pin values in the remaining bit times of the frame have no effect on the outputs.
- R7: `out_valid` is high for exactly the one clock cycle that follows the edge sampling a word's last bit, and the new words appear in that same cycle. At all other times `out_i` and `out_q` keep their last values.
- R8: With lead L = `cfg_lead` (0 to 3), `frame_strobe` is high for one clock cycle. That cycle ends at the sampling edge that comes L bit times before an MSB sample, with the lead taken modulo the frame interval. The strobe is never high outside a sampling cycle or before the first sync.
- R9: `cfg_err` goes high one cycle after the configuration gives `cfg_interval`=0, or gives a frame interval shorter than the bit times the word needs in the selected mode. While `cfg_err` is high, `out_valid` stays low.
- R10: After reset, `out_valid`, `frame_strobe`, `out_i`, `out_q` and `cfg_err` are 0. No word is produced and no strobe is driven until a sync has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Restarts divider and framing |
| cfg_clkdiv | input | DIV_W | Bit clock = clk / (cfg_clkdiv+1) |
| cfg_bits | input | $clog2(WORD_W) | Word length minus one |
| cfg_interval | input | FRM_W | Frame interval in bit times (1 to 127) |
| cfg_lead | input | LEAD_W | Strobe lead ahead of the MSB, in bit times |
| cfg_four_pin | input | 1 | 0: two-pin mode, 1: four-pin mode |
| ser_pins | input | 4 | Serial data pins A, B, C, D at bits 0 to 3 |
| frame_strobe | output | 1 | Tells the sender an MSB is due |
| out_valid | output | 1 | One-cycle word-ready pulse |
| out_i | output | WORD_W | Parallel I word |
| out_q | output | WORD_W | Parallel Q word |
| cfg_err | output | 1 | Frame interval too short for the word |

## Verification
Counting from the sync edge E0, capture edge m falls at E0+3+`cfg_clkdiv`+m*(`cfg_clkdiv`+1). The words and `out_valid` from a last-slot capture are due in the cycle right after that edge. `frame_strobe` is due in the cycle that ends at its capture edge, and `cfg_err` is due one cycle after the configuration changes. The bench numbers every edge after the sync and computes which edges are captures and which frame slot each one holds. It drives the pins only on capture edges and drives noise on all other edges. On each falling edge it checks the strobe against the edge that follows and checks the words against the edge just passed. No output is checked for the first two edges after sync, because samples left over from the previous phase may still land there.

// File: rtl/ser_iq_pkg.sv
package ser_iq_pkg;
  typedef enum logic {
    PIN_TWO  = 1'b0,
    PIN_FOUR = 1'b1
  } pin_mode_e;

  localparam int N_LANES = 2;
  localparam int N_PINS  = 4;
endpackage

// File: rtl/ser_bitclk_div.sv
module ser_bitclk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = (cnt == div_sel) && !restart;
  assign cnt_o  = cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ser_frame_seq.sv
module ser_frame_seq #(
  parameter int FRM_W  = 7,
  parameter int LEAD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [FRM_W-1:0]  interval,
  input  logic [LEAD_W-1:0] lead,
  input  logic [FRM_W-1:0]  slots,
  output logic              cap_en,
  output logic              first_slot,
  output logic              last_slot,
  output logic              strobe
);
  localparam int LEAD_MAX = (1 << LEAD_W);

  logic [FRM_W-1:0] pos;
  logic             armed;
  logic [FRM_W-1:0] lead_mod;
  logic [FRM_W-1:0] tgt;
  logic [FRM_W:0]   pos_inc;

  always_comb begin
    lead_mod = FRM_W'(lead);
    for (int k = 0; k < LEAD_MAX; k++) begin
      if (interval != '0 && lead_mod >= interval) begin
        lead_mod = lead_mod - interval;
      end
    end
    tgt = (lead_mod == '0) ? '0 : (interval - lead_mod);
  end

  assign pos_inc    = {1'b0, pos} + 1'b1;
  assign cap_en     = tick && armed && (pos < slots);
  assign first_slot = (pos == '0);
  assign last_slot  = (pos == slots - 1'b1);
  assign strobe     = tick && armed && (pos == tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      pos   <= '0;
      armed <= 1'b1;
    end else if (tick) begin
      if (pos_inc >= {1'b0, interval}) begin
        pos <= '0;
      end else begin
        pos <= pos_inc[FRM_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ser_lane_asm.sv
module ser_lane_asm #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              first,
  input  logic              pair,
  input  logic              hi_bit,
  input  logic              lo_bit,
  input  logic              emit,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr;
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] nxt;

  always_comb begin
    base = first ? '0 : sr;
    if (pair) begin
      nxt = {base[WORD_W-3:0], hi_bit, lo_bit};
    end else begin
      nxt = {base[WORD_W-2:0], hi_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      word_o <= '0;
    end else begin
      if (load) begin
        sr <= nxt;
      end
      if (emit) begin
        word_o <= nxt;
      end
    end
  end
endmodule

// File: rtl/ser_iq_deser.sv
module ser_iq_deser
  import ser_iq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 4,
  parameter int FRM_W  = 7,
  parameter int LEAD_W = 2,
  localparam int BITS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic [DIV_W-1:0]  cfg_clkdiv,
  input  logic [BITS_W-1:0] cfg_bits,
  input  logic [FRM_W-1:0]  cfg_interval,
  input  logic [LEAD_W-1:0] cfg_lead,
  input  logic              cfg_four_pin,
  input  logic [3:0]        ser_pins,
  output logic              frame_strobe,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_i,
  output logic [WORD_W-1:0] out_q,
  output logic              cfg_err
);
  pin_mode_e         mode;
  logic              four;
  logic              sync_q1, sync_q2;
  logic              bit_tick;
  logic [DIV_W-1:0]  div_cnt;
  logic [BITS_W:0]   word_len;
  logic [BITS_W:0]   half_len;
  logic [FRM_W-1:0]  slots;
  logic              cap_en, first_slot, last_slot;
  logic              last_odd, pair, emit;
  logic              err_q, valid_q;
  logic [WORD_W-1:0] lane_word [N_LANES];

  assign mode     = pin_mode_e'(cfg_four_pin);
  assign four     = (mode == PIN_FOUR);
  assign word_len = {1'b0, cfg_bits} + 1'b1;
  assign half_len = (word_len + 1'b1) >> 1;
  assign slots    = four ? FRM_W'(half_len) : FRM_W'(word_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= sync_in;
      sync_q2 <= sync_q1;
    end
  end

  ser_bitclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (sync_q2),
    .div_sel (cfg_clkdiv),
    .tick_o  (bit_tick),
    .cnt_o   (div_cnt)
  );

  ser_frame_seq #(.FRM_W(FRM_W), .LEAD_W(LEAD_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .restart    (sync_q2),
    .tick       (bit_tick),
    .interval   (cfg_interval),
    .lead       (cfg_lead),
    .slots      (slots),
    .cap_en     (cap_en),
    .first_slot (first_slot),
    .last_slot  (last_slot),
    .strobe     (frame_strobe)
  );

  assign last_odd = four && !cfg_bits[0] && last_slot;
  assign pair     = four && !last_odd;
  assign emit     = cap_en && last_slot && !err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      err_q   <= (cfg_interval == '0) || (slots > cfg_interval);
      valid_q <= emit;
    end
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic hi_pin, lo_pin;
    if (g == 0) begin : g_i
      assign hi_pin = ser_pins[0];
      assign lo_pin = ser_pins[1];
    end else begin : g_q
      assign hi_pin = four ? ser_pins[2] : ser_pins[1];
      assign lo_pin = ser_pins[3];
    end
    ser_lane_asm #(.WORD_W(WORD_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load   (cap_en),
      .first  (first_slot),
      .pair   (pair),
      .hi_bit (hi_pin),
      .lo_bit (lo_pin),
      .emit   (emit),
      .word_o (lane_word[g])
    );
  end

  assign out_i     = lane_word[0];
  assign out_q     = lane_word[1];
  assign out_valid = valid_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/ser_iq_deser_chk.sv
module ser_iq_deser_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_in,
  input logic             bit_tick,
  input logic [DIV_W-1:0] div_cnt,
  input logic             frame_strobe,
  input logic             out_valid,
  input logic             cfg_err
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= '0;
    end else if (age != 2'd3) begin
      age <= age + 1'b1;
    end
  end

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(sync_in, 3)) |-> (div_cnt == '0)); // R1

  AST_NO_TICK_IN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(sync_in, 2)) |-> !bit_tick); // R2

  AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(bit_tick)); // R7

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> bit_tick); // R8

  AST_ERR_MUTES_VALID: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_err) |-> !out_valid); // R9
endmodule

bind ser_iq_deser ser_iq_deser_chk #(.DIV_W(DIV_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sync_in      (sync_in),
  .bit_tick     (bit_tick),
  .div_cnt      (div_cnt),
  .frame_strobe (frame_strobe),
  .out_valid    (out_valid),
  .cfg_err      (cfg_err)
);

// File: tb/sim_ser_iq_deser.sv
module sim_ser_iq_deser;
  localparam int WORD_W = 16;
  localparam int DIV_W  = 4;
  localparam int FRM_W  = 7;
  localparam int LEAD_W = 2;
  localparam int BITS_W = $clog2(WORD_W);

  logic              clk = 1'b0;
  logic              rst;
  logic              sync_in;
  logic [DIV_W-1:0]  cfg_clkdiv;
  logic [BITS_W-1:0] cfg_bits;
  logic [FRM_W-1:0]  cfg_interval;
  logic [LEAD_W-1:0] cfg_lead;
  logic              cfg_four_pin;
  logic [3:0]        ser_pins;
  logic              frame_strobe, out_valid, cfg_err;
  logic [WORD_W-1:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int last_i = 0;
  int last_q = 0;

  always #10 clk = ~clk;

  ser_iq_deser #(.WORD_W(WORD_W), .DIV_W(DIV_W), .FRM_W(FRM_W), .LEAD_W(LEAD_W)) u0 (
    .clk(clk), .rst(rst), .sync_in(sync_in), .cfg_clkdiv(cfg_clkdiv),
    .cfg_bits(cfg_bits), .cfg_interval(cfg_interval), .cfg_lead(cfg_lead),
    .cfg_four_pin(cfg_four_pin), .ser_pins(ser_pins), .frame_strobe(frame_strobe),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int wordv(input int f, input int lane, input int seed, input int len);
    int v;
    v = (f * 97 + lane * 53 + seed * 29 + 32'h5a3) ^ (f << 3) ^ (seed << 7);
    return v & ((1 << len) - 1);
  endfunction

  function automatic int slots_of(input bit four, input int len);
    return four ? (len + 1) / 2 : len;
  endfunction

  task automatic run_cfg(input int cd, input bit four, input int len, input int intv,
                         input int lead, input int nfr, input int seed);
    int  slots, first, per, tgt, t_end, got;
    bit  bad;
    slots = slots_of(four, len);
    bad   = (intv == 0) || (slots > intv);
    @(negedge clk);
    cfg_clkdiv   = DIV_W'(cd);
    cfg_bits     = BITS_W'(len - 1);
    cfg_interval = FRM_W'(intv);
    cfg_lead     = LEAD_W'(lead);
    cfg_four_pin = four;
    repeat (3) @(negedge clk);
    // R9: error flag follows the configuration one cycle later
    chk(cfg_err == bad, "R9 cfg_err", int'(cfg_err), int'(bad));
    per   = cd + 1;
    first = 3 + cd;
    tgt   = bad ? 0 : (((lead % intv) == 0) ? 0 : intv - (lead % intv));
    t_end = first + nfr * (bad ? 4 : intv) * per + 2;
    got   = 0;
    sync_in = 1'b1;
    @(posedge clk);
    for (int e = 1; e <= t_end; e++) begin
      @(negedge clk);
      sync_in = 1'b0;
      // outputs produced by edge e-1
      if (e - 1 >= 2) begin
        int  ep;
        bit  expv;
        int  f, m, pos;
        ep   = e - 1;
        expv = 1'b0;
        f    = 0;
        if (!bad && ep >= first && ((ep - first) % per) == 0) begin
          m   = (ep - first) / per;
          pos = m % intv;
          f   = m / intv;
          expv = (pos == slots - 1);
        end
        if (bad) begin
          chk(out_valid == 1'b0, "R9 valid muted", int'(out_valid), 0);
        end else begin
          chk(out_valid == expv, "R7 valid timing", int'(out_valid), int'(expv));
        end
        if (expv) begin
          int wi, wq;
          wi = wordv(f, 0, seed, len);
          wq = wordv(f, 1, seed, len);
          if (four) begin
            chk(int'(out_i) == wi, "R4 four-pin I", int'(out_i), wi);
            chk(int'(out_q) == wq, "R4 four-pin Q", int'(out_q), wq);
          end else begin
            chk(int'(out_i) == wi, "R3 two-pin I", int'(out_i), wi);
            chk(int'(out_q) == wq, "R3 two-pin Q", int'(out_q), wq);
          end
          if (f == 0) chk(int'(out_i) == wi, "R2 first MSB after sync", int'(out_i), wi);
          if (intv > slots) chk(int'(out_q) == wq, "R6 idle slots ignored", int'(out_q), wq);
          chk((int'(out_i) >> len) == 0 && (int'(out_q) >> len) == 0,
              "R5 upper bits zero", int'(out_i) | int'(out_q), wi | wq);
          last_i = wi;
          last_q = wq;
          got++;
        end else if (!bad && got > 0) begin
          chk(int'(out_i) == last_i && int'(out_q) == last_q, "R7 words held",
              int'(out_i), last_i);
        end
        if (bad) chk(cfg_err == 1'b1, "R9 flag held", int'(cfg_err), 1);
      end
      // strobe for the cycle ending at edge e
      if (e >= 2 && !bad) begin
        bit exps;
        exps = 1'b0;
        if (e >= first && ((e - first) % per) == 0)
          exps = (((e - first) / per) % intv) == tgt;
        if (intv == 1) begin
          chk(frame_strobe == exps, "R1 bit-time spacing", int'(frame_strobe), int'(exps));
        end else begin
          chk(frame_strobe == exps, "R8 strobe lead", int'(frame_strobe), int'(exps));
        end
      end
      // pins for edge e
      begin
        logic [3:0] p;
        p = 4'((e * 5 + seed * 3) ^ (e >> 1));
        if (!bad && e >= first && ((e - first) % per) == 0) begin
          int m, pos, f, wi, wq, hi, lo;
          m   = (e - first) / per;
          pos = m % intv;
          f   = m / intv;
          wi  = wordv(f, 0, seed, len);
          wq  = wordv(f, 1, seed, len);
          if (pos < slots) begin
            if (!four) begin
              p[0] = 1'((wi >> (len - 1 - pos)) & 1);
              p[1] = 1'((wq >> (len - 1 - pos)) & 1);
            end else begin
              hi = len - 1 - 2 * pos;
              lo = len - 2 - 2 * pos;
              p[0] = 1'((wi >> hi) & 1);
              p[2] = 1'((wq >> hi) & 1);
              if (lo >= 0) begin
                p[1] = 1'((wi >> lo) & 1);
                p[3] = 1'((wq >> lo) & 1);
              end
            end
          end
        end
        ser_pins = p;
      end
    end
  endtask

  initial begin
    rst          = 1'b1;
    sync_in      = 1'b0;
    cfg_clkdiv   = '0;
    cfg_bits     = BITS_W'(7);
    cfg_interval = FRM_W'(8);
    cfg_lead     = '0;
    cfg_four_pin = 1'b0;
    ser_pins     = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0 && frame_strobe == 1'b0, "R10 reset handshake",
        int'(out_valid) | int'(frame_strobe), 0);
    chk(out_i == '0 && out_q == '0, "R10 reset words", int'(out_i | out_q), 0);
    chk(cfg_err == 1'b0, "R10 reset err", int'(cfg_err), 0);
    rst = 1'b0;
    // R10: nothing before the first sync
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      ser_pins = 4'(c * 7 + 3);
      chk(out_valid == 1'b0 && frame_strobe == 1'b0, "R10 idle before sync",
          int'(out_valid) | int'(frame_strobe), 0);
    end
    for (int cd = 0; cd < 3; cd++)
      for (int fp = 0; fp < 2; fp++)
        for (int ld = 0; ld < 4; ld++) begin
          int len;
          len = 5 + ld;
          run_cfg(cd, fp[0], len, slots_of(fp[0], len) + (ld % 3), ld, 3, cd * 8 + fp * 4 + ld);
        end
    run_cfg(5, 1'b1, 16, 8, 1, 3, 41);
    run_cfg(0, 1'b0, 16, 16, 3, 3, 42);
    run_cfg(2, 1'b0, 1, 1, 0, 6, 43);
    run_cfg(1, 1'b1, 1, 1, 2, 6, 44);
    run_cfg(0, 1'b0, 8, 4, 0, 3, 45);
    run_cfg(1, 1'b1, 3, 0, 1, 3, 46);
    run_cfg(0, 1'b1, 6, 3, 2, 3, 47);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule